// File: doc/BRIEF.md
# Timer Interrupt Routing Unit

This block sits between a bank of timer channels and the interrupt fabric. Each channel raises a one-cycle expiry pulse. The block then decides how that event leaves the chip, based on the channel's configuration and a global legacy-routing switch. There are three outcomes. The event can become an address/data message carrying a vector and a destination. It can become a request on a numbered interrupt-controller pin, in either edge or level style. Or it can be discarded. For level-style pins the block keeps a per-channel status bit. That bit stays set until software clears it with a write-one-to-clear mask, or until a configuration change makes the held line stale.

Two write paths share one port, and `wr_sel` chooses between them. With `wr_sel` low, the word updates the channel's configuration. The fields in that word are: level select at bit 1, interrupt enable at bit 2, pin route at bits 13:9 and message enable at bit 14. The message-capable flag at bit 15 is fixed by a parameter, and so is the allowed-pin mask at bits 63:32; writes to either are ignored. With `wr_sel` high, the word updates the channel's message route: the vector sits in bits 7:0 and the destination in bits 51:44. A write and an expiry on the same channel in the same cycle are evaluated against the newly written values.

Pin requests and messages leave on two independent valid/ready streams. Each channel owns one pending slot per stream. A pending request stays on the stream with stable fields until `*_ready` is high at a clock edge. There is one exception: a level assert that software clears before it is taken is withdrawn. Channels whose slots hold requests are served round-robin. An expiry that needs a slot that is still occupied is lost.

Top module: `tirq_router`

## Requirements
- R1: With interrupt enable (bit 2) set, level select (bit 1) clear and message delivery off, an expiry issues a pin request with op code 1 (pulse) on the pin held in route bits 13:9, and leaves the status bit clear.
- R2: With level select set, an expiry issues op code 2 (assert) on the routed pin and sets that channel's bit in `irq_status`. Further expiries on that channel are ignored while the bit is set.
- R3: An expiry is ignored when interrupt enable is clear. It is also dropped without any output when the effective pin is 0.
- R4: A written route whose bit is clear in the allowed-pin mask is stored as 0. By default the mask allows pins 20 to 23 only.
- R5: While `legacy_en` is high, channel 0 always pulses pin 2 and channel 1 always pulses pin 8. This applies whatever their route, level or message settings are. Other channels are unaffected.
- R6: A channel uses message delivery only when message-capable (bit 15) and message enable (bit 14) are both set. In that case it issues no pin request and no status bit. The message carries route bits 7:0 as `msg_vector` and bits 51:44 as `msg_dest`, and `msg_bcast` is high when the destination is 0xFF.
- R7: A cycle with `clr_en` high clears only those status bits that are both set and written 1 in `clr_mask`. Each cleared bit issues op code 3 (deassert) on the pin it had asserted.
- R8: If a status bit is cleared while its assert request has not yet been taken, the assert is withdrawn and no deassert is issued.
- R9: A configuration write to a channel with its status bit set clears that bit and deasserts the old pin, when the new setting disables interrupts, selects message delivery, selects edge mode, or changes the pin. Otherwise the bit stays set.
- R10: A valid pin or message request holds its fields until taken. Only a withdrawn assert is exempt. Each channel has one pending slot per stream, and an expiry that needs an occupied slot is lost.
- R11: After reset all status bits are clear and neither stream is valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| legacy_en | input | 1 | Global legacy routing switch for channels 0 and 1 |
| expire | input | NCH | Per-channel expiry pulses |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | 0: configuration word, 1: message route word |
| wr_ch | input | CHW | Channel addressed by the write |
| wr_data | input | 64 | Write word |
| clr_en | input | 1 | Status clear strobe |
| clr_mask | input | NCH | Write-one-to-clear mask for status |
| irq_status | output | NCH | Per-channel level status bits |
| pin_valid | output | 1 | Pin request available |
| pin_ready | input | 1 | Consumer takes the pin request |
| pin_op | output | 2 | 1 pulse, 2 assert, 3 deassert |
| pin_num | output | 5 | Target pin |
| msg_valid | output | 1 | Message available |
| msg_ready | input | 1 | Consumer takes the message |
| msg_vector | output | 8 | Message vector |
| msg_dest | output | 8 | Message destination |
| msg_bcast | output | 1 | Destination is broadcast |

## Verification
The hardest state to reach is a status bit that is set while its assert request is still sitting unaccepted in the channel slot. Only that state separates a withdrawn assert from a deassert. The bench reaches it by holding `pin_ready` low through a level expiry and a following clear. It also uses the opposite order, accepting the assert first, to show that the deassert carries the originally asserted pin even after a configuration write has changed the route.

// File: rtl/tirq_pkg.sv
package tirq_pkg;

  typedef enum logic [1:0] {
    OP_NONE     = 2'd0,
    OP_PULSE    = 2'd1,
    OP_ASSERT   = 2'd2,
    OP_DEASSERT = 2'd3
  } pin_op_e;

  localparam int PIN_W  = 5;
  localparam int VEC_W  = 8;
  localparam int DEST_W = 8;

  // configuration word field positions
  localparam int CFG_LVL_BIT  = 1;
  localparam int CFG_IEN_BIT  = 2;
  localparam int CFG_ROUTE_LO = 9;
  localparam int CFG_MEN_BIT  = 14;

  // message route word field positions
  localparam int MR_VEC_LO  = 0;
  localparam int MR_DEST_LO = 44;

endpackage

// File: rtl/tirq_rr_arb.sv
module tirq_rr_arb #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] req,
  input  logic         ready,
  output logic         valid,
  output logic [N-1:0] gnt
);
  localparam int IW = (N > 1) ? $clog2(N) : 1;

  logic [IW-1:0] ptr_q;
  logic          hold_q;
  logic [N-1:0]  hold_gnt_q;
  logic [N-1:0]  rr_gnt;
  logic [IW-1:0] win;
  logic          found;

  always_comb begin
    rr_gnt = '0;
    found  = 1'b0;
    for (int i = 0; i < N; i++) begin
      int j;
      j = int'(ptr_q) + i;
      if (j >= N) j = j - N;
      if (!found && req[IW'(j)]) begin
        rr_gnt[IW'(j)] = 1'b1;
        found = 1'b1;
      end
    end
  end

  assign valid = |req;
  assign gnt   = (hold_q && |(hold_gnt_q & req)) ? hold_gnt_q : rr_gnt;

  always_comb begin
    win = '0;
    for (int i = 0; i < N; i++)
      if (gnt[i]) win = IW'(i);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr_q      <= '0;
      hold_q     <= 1'b0;
      hold_gnt_q <= '0;
    end else if (valid && ready) begin
      ptr_q  <= (int'(win) == N - 1) ? '0 : win + 1'b1;
      hold_q <= 1'b0;
    end else if (valid) begin
      hold_q     <= 1'b1;
      hold_gnt_q <= gnt;
    end else begin
      hold_q <= 1'b0;
    end
  end

  // R10
  gnt_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt) && (valid == (gnt != '0)));

  // R10
  gnt_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && !ready) |=> (gnt == $past(gnt)) || (($past(gnt) & req) == '0));

endmodule

// File: rtl/tirq_chan.sv
module tirq_chan
  import tirq_pkg::*;
#(
  parameter int          IDX        = 0,
  parameter logic [31:0] ALLOW_MASK = 32'h00F0_0000,
  parameter bit          MSG_CAP    = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              legacy_en,
  input  logic              expire,
  input  logic              cfg_we,
  input  logic              msg_we,
  input  logic              wr_lvl,
  input  logic              wr_ien,
  input  logic              wr_men,
  input  logic [PIN_W-1:0]  wr_route,
  input  logic [VEC_W-1:0]  wr_vec,
  input  logic [DEST_W-1:0] wr_dest,
  input  logic              clr,
  input  logic              pin_pop,
  input  logic              msg_pop,
  output logic              status,
  output logic              pin_req,
  output pin_op_e           pin_op,
  output logic [PIN_W-1:0]  pin_num,
  output logic              msg_req,
  output logic [VEC_W-1:0]  msg_vec,
  output logic [DEST_W-1:0] msg_dest
);
  localparam bit IS_LEG = (IDX < 2);
  localparam logic [PIN_W-1:0] LEG_PIN = (IDX == 0) ? PIN_W'(2) : PIN_W'(8);

  // stored configuration
  logic              lvl_q, ien_q, men_q;
  logic [PIN_W-1:0]  route_q;
  logic [VEC_W-1:0]  mvec_q;
  logic [DEST_W-1:0] mdest_q;
  // level bookkeeping
  logic              status_q;
  logic [PIN_W-1:0]  held_q;
  // pending slots
  pin_op_e           pop_q;
  logic [PIN_W-1:0]  ppin_q;
  logic              mslot_q;
  logic [VEC_W-1:0]  svec_q;
  logic [DEST_W-1:0] sdest_q;

  // effective configuration including a same-cycle write
  logic              n_lvl, n_ien, n_men;
  logic [PIN_W-1:0]  n_route, wr_route_ok;
  logic [VEC_W-1:0]  n_vec;
  logic [DEST_W-1:0] n_dest;
  logic              leg_ch, use_msg, edge_mode;
  logic [PIN_W-1:0]  eff_pin;
  logic              pslot_free, mslot_free;
  logic              fire, fire_msg, fire_pin, drop_cfg, release_st;
  pin_op_e           op_after_pop;

  assign wr_route_ok = (wr_route == '0 || ALLOW_MASK[wr_route]) ? wr_route : '0;

  always_comb begin
    n_lvl   = cfg_we ? wr_lvl      : lvl_q;
    n_ien   = cfg_we ? wr_ien      : ien_q;
    n_men   = cfg_we ? wr_men      : men_q;
    n_route = cfg_we ? wr_route_ok : route_q;
    n_vec   = msg_we ? wr_vec      : mvec_q;
    n_dest  = msg_we ? wr_dest     : mdest_q;
  end

  assign leg_ch    = legacy_en && IS_LEG;
  assign use_msg   = !leg_ch && MSG_CAP && n_men;
  assign eff_pin   = use_msg ? '0 : (leg_ch ? LEG_PIN : n_route);
  assign edge_mode = leg_ch || !n_lvl;

  assign pslot_free = (pop_q == OP_NONE) || pin_pop;
  assign mslot_free = !mslot_q || msg_pop;

  assign fire     = expire && n_ien && !status_q;
  assign fire_msg = fire && use_msg && mslot_free;
  assign fire_pin = fire && !use_msg && (eff_pin != '0) && pslot_free;

  assign drop_cfg   = cfg_we && (!n_ien || use_msg || edge_mode || (eff_pin != held_q));
  assign release_st = status_q && (clr || drop_cfg);

  assign op_after_pop = pin_pop ? OP_NONE : pop_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lvl_q    <= 1'b0;
      ien_q    <= 1'b0;
      men_q    <= 1'b0;
      route_q  <= '0;
      mvec_q   <= '0;
      mdest_q  <= '0;
      status_q <= 1'b0;
      held_q   <= '0;
      pop_q    <= OP_NONE;
      ppin_q   <= '0;
      mslot_q  <= 1'b0;
      svec_q   <= '0;
      sdest_q  <= '0;
    end else begin
      lvl_q   <= n_lvl;
      ien_q   <= n_ien;
      men_q   <= n_men;
      route_q <= n_route;
      mvec_q  <= n_vec;
      mdest_q <= n_dest;

      // pin slot and level status
      if (release_st) begin
        status_q <= 1'b0;
        if (op_after_pop == OP_ASSERT) begin
          pop_q <= OP_NONE;
        end else begin
          pop_q  <= OP_DEASSERT;
          ppin_q <= held_q;
        end
      end else if (fire_pin) begin
        pop_q  <= edge_mode ? OP_PULSE : OP_ASSERT;
        ppin_q <= eff_pin;
        if (!edge_mode) begin
          status_q <= 1'b1;
          held_q   <= eff_pin;
        end
      end else begin
        pop_q <= op_after_pop;
      end

      // message slot
      if (fire_msg) begin
        mslot_q <= 1'b1;
        svec_q  <= n_vec;
        sdest_q <= n_dest;
      end else if (msg_pop) begin
        mslot_q <= 1'b0;
      end
    end
  end

  assign status   = status_q;
  assign pin_req  = (pop_q != OP_NONE);
  assign pin_op   = pop_q;
  assign pin_num  = ppin_q;
  assign msg_req  = mslot_q;
  assign msg_vec  = svec_q;
  assign msg_dest = sdest_q;

  // R2
  status_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status_q) |-> $past(expire) && $past(pop_q != OP_ASSERT || pin_pop));

  // R7
  status_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(status_q) |-> $past(clr || cfg_we));

  // R3
  ien_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && !n_ien && !clr && !cfg_we) |=> $stable(status_q) && !$rose(mslot_q));

  // R5
  leg_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (leg_ch && expire && !status_q) |=> (status_q == $past(status_q)) && !$rose(mslot_q));

  // R8
  slot_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    status_q |-> (pop_q == OP_ASSERT || pop_q == OP_NONE));

endmodule

// File: rtl/tirq_router.sv
module tirq_router
  import tirq_pkg::*;
#(
  parameter int          NCH        = 8,
  parameter logic [31:0] ALLOW_MASK = 32'h00F0_0000,
  parameter bit          MSG_CAP    = 1'b1,
  localparam int         CHW        = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           legacy_en,
  input  logic [NCH-1:0] expire,
  input  logic           wr_en,
  input  logic           wr_sel,
  input  logic [CHW-1:0] wr_ch,
  input  logic [63:0]    wr_data,
  input  logic           clr_en,
  input  logic [NCH-1:0] clr_mask,
  output logic [NCH-1:0] irq_status,
  output logic           pin_valid,
  input  logic           pin_ready,
  output logic [1:0]     pin_op,
  output logic [4:0]     pin_num,
  output logic           msg_valid,
  input  logic           msg_ready,
  output logic [7:0]     msg_vector,
  output logic [7:0]     msg_dest,
  output logic           msg_bcast
);
  logic              wr_lvl, wr_ien, wr_men;
  logic [PIN_W-1:0]  wr_route;
  logic [VEC_W-1:0]  wr_vec;
  logic [DEST_W-1:0] wr_dst;
  logic              unused_bits;

  assign wr_lvl   = wr_data[CFG_LVL_BIT];
  assign wr_ien   = wr_data[CFG_IEN_BIT];
  assign wr_men   = wr_data[CFG_MEN_BIT];
  assign wr_route = wr_data[CFG_ROUTE_LO +: PIN_W];
  assign wr_vec   = wr_data[MR_VEC_LO +: VEC_W];
  assign wr_dst   = wr_data[MR_DEST_LO +: DEST_W];
  assign unused_bits = ^{wr_data[63:52], wr_data[43:15], wr_data[8]};

  logic [NCH-1:0]    pin_req, msg_req, pin_gnt, msg_gnt;
  pin_op_e           ch_op   [NCH];
  logic [PIN_W-1:0]  ch_pin  [NCH];
  logic [VEC_W-1:0]  ch_vec  [NCH];
  logic [DEST_W-1:0] ch_dest [NCH];

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    logic hit;
    assign hit = wr_en && (wr_ch == CHW'(g));

    tirq_chan #(
      .IDX       (g),
      .ALLOW_MASK(ALLOW_MASK),
      .MSG_CAP   (MSG_CAP)
    ) u_chan (
      .clk      (clk),
      .rst_n    (rst_n),
      .legacy_en(legacy_en),
      .expire   (expire[g]),
      .cfg_we   (hit && !wr_sel),
      .msg_we   (hit && wr_sel),
      .wr_lvl   (wr_lvl),
      .wr_ien   (wr_ien),
      .wr_men   (wr_men),
      .wr_route (wr_route),
      .wr_vec   (wr_vec),
      .wr_dest  (wr_dst),
      .clr      (clr_en && clr_mask[g]),
      .pin_pop  (pin_gnt[g] && pin_ready),
      .msg_pop  (msg_gnt[g] && msg_ready),
      .status   (irq_status[g]),
      .pin_req  (pin_req[g]),
      .pin_op   (ch_op[g]),
      .pin_num  (ch_pin[g]),
      .msg_req  (msg_req[g]),
      .msg_vec  (ch_vec[g]),
      .msg_dest (ch_dest[g])
    );
  end

  tirq_rr_arb #(.N(NCH)) u_pin_arb (
    .clk  (clk),
    .rst_n(rst_n),
    .req  (pin_req),
    .ready(pin_ready),
    .valid(pin_valid),
    .gnt  (pin_gnt)
  );

  tirq_rr_arb #(.N(NCH)) u_msg_arb (
    .clk  (clk),
    .rst_n(rst_n),
    .req  (msg_req),
    .ready(msg_ready),
    .valid(msg_valid),
    .gnt  (msg_gnt)
  );

  always_comb begin
    pin_op     = '0;
    pin_num    = '0;
    msg_vector = '0;
    msg_dest   = '0;
    for (int i = 0; i < NCH; i++) begin
      if (pin_gnt[i]) begin
        pin_op  = pin_op | ch_op[i];
        pin_num = pin_num | ch_pin[i];
      end
      if (msg_gnt[i]) begin
        msg_vector = msg_vector | ch_vec[i];
        msg_dest   = msg_dest | ch_dest[i];
      end
    end
  end

  assign msg_bcast = (msg_dest == 8'hFF);

  // R10
  pin_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_valid && !pin_ready && pin_op != OP_ASSERT)
      |=> pin_valid && $stable(pin_op) && $stable(pin_num));

  // R10
  msg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && !msg_ready)
      |=> msg_valid && $stable(msg_vector) && $stable(msg_dest));

  // R11
  reset_quiet_chk: assert property (@(posedge clk)
    $past(!rst_n) |-> (irq_status == '0) && !pin_valid && !msg_valid);

endmodule

// File: tb/tirq_router_bench.sv
module tirq_router_bench;
  localparam int NCH = 8;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           legacy_en = 1'b0;
  logic [NCH-1:0] expire = '0;
  logic           wr_en = 1'b0;
  logic           wr_sel = 1'b0;
  logic [2:0]     wr_ch = '0;
  logic [63:0]    wr_data = '0;
  logic           clr_en = 1'b0;
  logic [NCH-1:0] clr_mask = '0;
  logic [NCH-1:0] irq_status;
  logic           pin_valid;
  logic           pin_ready = 1'b0;
  logic [1:0]     pin_op;
  logic [4:0]     pin_num;
  logic           msg_valid;
  logic           msg_ready = 1'b0;
  logic [7:0]     msg_vector;
  logic [7:0]     msg_dest;
  logic           msg_bcast;

  int total = 0;
  int bad = 0;

  always #5 clk = ~clk;

  tirq_router #(.NCH(NCH)) u_tirq_router (
    .clk(clk), .rst_n(rst_n), .legacy_en(legacy_en), .expire(expire),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_ch(wr_ch), .wr_data(wr_data),
    .clr_en(clr_en), .clr_mask(clr_mask), .irq_status(irq_status),
    .pin_valid(pin_valid), .pin_ready(pin_ready), .pin_op(pin_op), .pin_num(pin_num),
    .msg_valid(msg_valid), .msg_ready(msg_ready), .msg_vector(msg_vector),
    .msg_dest(msg_dest), .msg_bcast(msg_bcast)
  );

  typedef struct packed {
    logic [3:0]  rq;
    logic [2:0]  ch;
    logic [15:0] cfg;
    logic        leg;
    logic [7:0]  dest;
    logic        pv;
    logic [1:0]  op;
    logic [4:0]  pin;
    logic        mv;
    logic        bc;
    logic        st;
  } vec_t;

  // cfg: bit1 level, bit2 enable, 13:9 route, bit14 message enable
  localparam vec_t TBL [12] = '{
    '{4'd1, 3'd3, 16'h2804, 1'b0, 8'h11, 1'b1, 2'd1, 5'd20, 1'b0, 1'b0, 1'b0},
    '{4'd2, 3'd3, 16'h2A06, 1'b0, 8'h11, 1'b1, 2'd2, 5'd21, 1'b0, 1'b0, 1'b1},
    '{4'd3, 3'd3, 16'h2800, 1'b0, 8'h11, 1'b0, 2'd0, 5'd0,  1'b0, 1'b0, 1'b0},
    '{4'd4, 3'd3, 16'h0A04, 1'b0, 8'h11, 1'b0, 2'd0, 5'd0,  1'b0, 1'b0, 1'b0},
    '{4'd5, 3'd0, 16'h2806, 1'b1, 8'h11, 1'b1, 2'd1, 5'd2,  1'b0, 1'b0, 1'b0},
    '{4'd5, 3'd1, 16'h6804, 1'b1, 8'h11, 1'b1, 2'd1, 5'd8,  1'b0, 1'b0, 1'b0},
    '{4'd5, 3'd2, 16'h2C06, 1'b1, 8'h11, 1'b1, 2'd2, 5'd22, 1'b0, 1'b0, 1'b1},
    '{4'd6, 3'd4, 16'h6804, 1'b0, 8'h11, 1'b0, 2'd0, 5'd0,  1'b1, 1'b0, 1'b0},
    '{4'd6, 3'd5, 16'h4004, 1'b0, 8'hFF, 1'b0, 2'd0, 5'd0,  1'b1, 1'b1, 1'b0},
    '{4'd1, 3'd0, 16'h2E04, 1'b0, 8'h11, 1'b1, 2'd1, 5'd23, 1'b0, 1'b0, 1'b0},
    '{4'd3, 3'd6, 16'h0004, 1'b0, 8'h11, 1'b0, 2'd0, 5'd0,  1'b0, 1'b0, 1'b0},
    '{4'd6, 3'd7, 16'h6806, 1'b1, 8'h11, 1'b0, 2'd0, 5'd0,  1'b1, 1'b0, 1'b0}
  };

  function automatic string rq_name(input logic [3:0] n);
    case (n)
      4'd1: return "R1";
      4'd2: return "R2";
      4'd3: return "R3";
      4'd4: return "R4";
      4'd5: return "R5";
      default: return "R6";
    endcase
  endfunction

  task automatic chk(input string rq, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    step();
    step();
    rst_n = 1'b1;
    step();
  endtask

  task automatic wr_cfg(input int ch, input logic [15:0] c);
    wr_en = 1'b1; wr_sel = 1'b0; wr_ch = 3'(ch);
    wr_data = {48'h0, c} | 64'hFFFF_FFFF_0000_0000;
    step();
    wr_en = 1'b0;
  endtask

  task automatic wr_msg(input int ch, input logic [7:0] vec, input logic [7:0] dst);
    wr_en = 1'b1; wr_sel = 1'b1; wr_ch = 3'(ch);
    wr_data = (64'(dst) << 44) | 64'(vec);
    step();
    wr_en = 1'b0;
  endtask

  task automatic fire(input logic [NCH-1:0] m);
    expire = m;
    step();
    expire = '0;
  endtask

  task automatic pop_pin();
    pin_ready = 1'b1;
    step();
    pin_ready = 1'b0;
  endtask

  task automatic clr(input logic [NCH-1:0] m);
    clr_en = 1'b1; clr_mask = m;
    step();
    clr_en = 1'b0; clr_mask = '0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL R10 watchdog expired: actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    do_reset();
    chk("R11", "status", 32'(irq_status), 0);
    chk("R11", "pin_valid", 32'(pin_valid), 0);
    chk("R11", "msg_valid", 32'(msg_valid), 0);

    for (int k = 0; k < 12; k++) begin
      vec_t v;
      v = TBL[k];
      do_reset();
      legacy_en = v.leg;
      wr_msg(int'(v.ch), 8'h40 + 8'(v.ch), v.dest);
      wr_cfg(int'(v.ch), v.cfg);
      fire(NCH'(1) << v.ch);
      chk(rq_name(v.rq), "pin_valid", 32'(pin_valid), 32'(v.pv));
      if (v.pv) begin
        chk(rq_name(v.rq), "pin_op", 32'(pin_op), 32'(v.op));
        chk(rq_name(v.rq), "pin_num", 32'(pin_num), 32'(v.pin));
      end
      chk(rq_name(v.rq), "msg_valid", 32'(msg_valid), 32'(v.mv));
      if (v.mv) begin
        chk(rq_name(v.rq), "msg_vector", 32'(msg_vector), 32'(8'h40 + 8'(v.ch)));
        chk(rq_name(v.rq), "msg_bcast", 32'(msg_bcast), 32'(v.bc));
      end
      chk(rq_name(v.rq), "status bit", 32'(irq_status[v.ch]), 32'(v.st));
      legacy_en = 1'b0;
    end

    // R2: set status blocks a second expiry
    do_reset();
    wr_cfg(3, 16'h2A06);
    fire(8'h08);
    pop_pin();
    fire(8'h08);
    chk("R2", "pin_valid after repeat expiry", 32'(pin_valid), 0);

    // R7: write-one-to-clear, only set bits, deassert on held pin
    wr_cfg(2, 16'h2C06);
    fire(8'h04);
    pop_pin();
    chk("R7", "status before clear", 32'(irq_status), 32'h0C);
    clr(8'h09);
    chk("R7", "status after clear", 32'(irq_status), 32'h04);
    chk("R7", "deassert op", 32'(pin_op), 3);
    chk("R7", "deassert pin", 32'(pin_num), 21);
    pop_pin();
    chk("R7", "stream idle", 32'(pin_valid), 0);

    // R8: clear before the assert is taken withdraws it
    do_reset();
    wr_cfg(3, 16'h2A06);
    fire(8'h08);
    chk("R8", "assert pending", 32'(pin_valid), 1);
    clr(8'h08);
    chk("R8", "withdrawn", 32'(pin_valid), 0);
    chk("R8", "status", 32'(irq_status), 0);

    // R9: configuration writes on a held level line
    do_reset();
    wr_cfg(3, 16'h2A06);
    fire(8'h08);
    pop_pin();
    wr_cfg(3, 16'h2A06);
    chk("R9", "same config keeps status", 32'(irq_status), 32'h08);
    chk("R9", "same config no request", 32'(pin_valid), 0);
    wr_cfg(3, 16'h2C06);
    chk("R9", "route change clears", 32'(irq_status), 0);
    chk("R9", "route change deassert op", 32'(pin_op), 3);
    chk("R9", "route change old pin", 32'(pin_num), 21);
    pop_pin();
    fire(8'h08);
    chk("R9", "assert on new pin", 32'(pin_num), 22);
    pop_pin();
    wr_cfg(3, 16'h2C04);
    chk("R9", "edge switch deassert", 32'({pin_valid, pin_op, pin_num}), 32'({1'b1, 2'd3, 5'd22}));
    pop_pin();

    // R10: back-pressure, ordering and lost expiries
    do_reset();
    wr_cfg(1, 16'h2804);
    wr_cfg(6, 16'h2E04);
    fire(8'h42);
    chk("R10", "first pin", 32'(pin_num), 20);
    step();
    chk("R10", "held while not ready", 32'({pin_valid, pin_op, pin_num}), 32'({1'b1, 2'd1, 5'd20}));
    pop_pin();
    chk("R10", "second pin", 32'(pin_num), 23);
    pop_pin();
    chk("R10", "drained", 32'(pin_valid), 0);
    fire(8'h02);
    fire(8'h02);
    pop_pin();
    chk("R10", "second expiry lost", 32'(pin_valid), 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule